// File: doc/BRIEF.md
# Sixteen-bit ALU with single-step shifter

This block is a purely combinational datapath unit. Two operands go through an eight-way arithmetic and logic stage, and a four-way shift stage then moves that result by at most one bit position. A datapath controller drives a 3-bit operation select and a 2-bit shift select and takes back the shifted word together with four condition flags: zero, sign, carry and overflow. There is no clock and no storage inside. The result settles within the same cycle in which the selects and operands are presented.

The zero and sign flags describe the word that leaves the shifter. The carry and overflow flags describe the arithmetic stage only. For addition, carry is the carry out of the top bit. For subtraction, carry means a borrow occurred. With that convention, unsigned comparisons read directly off the flags. For example, A below B is "carry set", and A above B is "carry clear and zero clear". Every non-arithmetic operation forces carry and overflow to zero. The bit pushed out by any shift is dropped.

Top module: `alu_shift_unit`

## Requirements
- R1: Operation select 3'b000 yields operand A, and 3'b001 yields operand B, ahead of the shift stage.
- R2: Select 3'b010 yields A+B modulo 2^16; carry is the carry out of bit 15, and overflow is set when the sum of the two signed operands falls outside -32768..32767.
- R3: Select 3'b011 yields A-B modulo 2^16; carry is set exactly when A < B as unsigned values (borrow), and overflow is set when the signed difference falls outside -32768..32767.
- R4: Select 3'b100 yields the bitwise inverse of A, and 3'b101 yields the bitwise inverse of B.
- R5: Select 3'b110 yields A AND B, and 3'b111 yields A OR B.
- R6: For every operation select other than 3'b010 and 3'b011, carry and overflow are both 0.
- R7: Shift select 2'b00 passes the stage-one value unchanged. Shift select 2'b01 shifts it left by one with bit 0 filled by 0; the bit lost from bit 15 does not alter the carry flag.
- R8: Shift select 2'b10 shifts right by one with bit 15 filled by 0.
- R9: Shift select 2'b11 shifts right by one with bit 15 keeping its previous value (sign replicated).
- R10: The zero flag is 1 exactly when the final, shifted result is all zeros, including when a shift empties a nonzero stage-one value.
- R11: The sign flag equals bit 15 of the final, shifted result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| alu_sel | input | 3 | Arithmetic/logic operation select |
| shf_sel | input | 2 | Shift operation select |
| result | output | 16 | Shifted result |
| flag_z | output | 1 | Final result is zero |
| flag_s | output | 1 | Bit 15 of final result |
| flag_c | output | 1 | Carry (add) or borrow (subtract), else 0 |
| flag_v | output | 1 | Signed overflow of add or subtract, else 0 |

## Verification
The hardest situations to produce are those where the two stages disagree. One is a carry or overflow from the adder, followed by a shift that discards the top bit. The other is a nonzero sum that a right shift turns into zero, so the zero flag must follow the shifter and not the adder. Operands are therefore drawn from a set built around the sign boundary (0x7FFF, 0x8000, 0xFFFF, 1, 2 and similar). This set is supplemented with pseudo-random words, and every ordered pair is crossed with all 32 select combinations. In this way, wraparound, borrow, both overflow directions and shift-to-zero cases all occur under every shift mode.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

    typedef enum logic [2:0] {
        OP_PASS_A = 3'b000,
        OP_PASS_B = 3'b001,
        OP_ADD    = 3'b010,
        OP_SUB    = 3'b011,
        OP_INV_A  = 3'b100,
        OP_INV_B  = 3'b101,
        OP_AND    = 3'b110,
        OP_OR     = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'b00,
        SH_LEFT = 2'b01,
        SH_LRT  = 2'b10,
        SH_ART  = 2'b11
    } shf_op_e;

endpackage

// File: rtl/alu_stage.sv
module alu_stage
    import alu_shift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] y_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int LOW = WIDTH - 1;

    logic [WIDTH:0] wide_sum;
    logic [LOW:0]   low_sum;
    logic [WIDTH-1:0] b_eff;
    logic           cin;

    always_comb begin
        cin      = (op_i == OP_SUB);
        b_eff    = cin ? ~b_i : b_i;
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
        low_sum  = {1'b0, a_i[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]} + {{(LOW){1'b0}}, cin};
        y_o      = '0;
        carry_o  = 1'b0;
        ovf_o    = 1'b0;
        unique case (op_i)
            OP_PASS_A: y_o = a_i;
            OP_PASS_B: y_o = b_i;
            OP_ADD: begin
                y_o     = wide_sum[WIDTH-1:0];
                carry_o = wide_sum[WIDTH];
                ovf_o   = wide_sum[WIDTH] ^ low_sum[LOW];
            end
            OP_SUB: begin
                y_o     = wide_sum[WIDTH-1:0];
                carry_o = ~wide_sum[WIDTH];
                ovf_o   = wide_sum[WIDTH] ^ low_sum[LOW];
            end
            OP_INV_A:  y_o = ~a_i;
            OP_INV_B:  y_o = ~b_i;
            OP_AND:    y_o = a_i & b_i;
            OP_OR:     y_o = a_i | b_i;
            default:   y_o = '0;
        endcase
    end

endmodule

// File: rtl/shift_stage.sv
module shift_stage
    import alu_shift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] d_i,
    input  shf_op_e          op_i,
    output logic [WIDTH-1:0] q_o
);
    always_comb begin
        unique case (op_i)
            SH_NONE: q_o = d_i;
            SH_LEFT: q_o = {d_i[WIDTH-2:0], 1'b0};
            SH_LRT:  q_o = {1'b0, d_i[WIDTH-1:1]};
            SH_ART:  q_o = {d_i[WIDTH-1], d_i[WIDTH-1:1]};
            default: q_o = d_i;
        endcase
    end

endmodule

// File: rtl/flag_stage.sv
module flag_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] r_i,
    output logic             zero_o,
    output logic             sign_o
);
    always_comb begin
        zero_o = ~|r_i;
        sign_o = r_i[WIDTH-1];
    end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_shift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [2:0]       alu_sel,
    input  logic [1:0]       shf_sel,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_s,
    output logic             flag_c,
    output logic             flag_v
);
    logic [WIDTH-1:0] stage1_y;
    logic [WIDTH-1:0] stage2_y;
    alu_op_e          op_sel;
    shf_op_e          sh_sel;

    assign op_sel = alu_op_e'(alu_sel);
    assign sh_sel = shf_op_e'(shf_sel);

    alu_stage #(.WIDTH(WIDTH)) u_alu (
        .a_i     (opa),
        .b_i     (opb),
        .op_i    (op_sel),
        .y_o     (stage1_y),
        .carry_o (flag_c),
        .ovf_o   (flag_v)
    );

    shift_stage #(.WIDTH(WIDTH)) u_shf (
        .d_i  (stage1_y),
        .op_i (sh_sel),
        .q_o  (stage2_y)
    );

    flag_stage #(.WIDTH(WIDTH)) u_flg (
        .r_i    (stage2_y),
        .zero_o (flag_z),
        .sign_o (flag_s)
    );

    assign result = stage2_y;

endmodule

// File: rtl/alu_shift_unit_chk.sv
module alu_shift_unit_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [2:0]       alu_sel,
    input logic [1:0]       shf_sel,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_s,
    input logic             flag_c,
    input logic             flag_v
);
    always_comb begin
        // R6
        cv_quiet_chk: assert (!(alu_sel != 3'b010 && alu_sel != 3'b011) || (!flag_c && !flag_v));
        // R1
        pass_a_chk: assert (!(alu_sel == 3'b000 && shf_sel == 2'b00) || result == opa);
        // R2
        add_sum_chk: assert (!(alu_sel == 3'b010 && shf_sel == 2'b00) || result == WIDTH'(opa + opb));
        // R7
        left_fill_chk: assert (!(shf_sel == 2'b01) || result[0] == 1'b0);
        // R8
        lrt_fill_chk: assert (!(shf_sel == 2'b10) || result[WIDTH-1] == 1'b0);
        // R9
        art_sign_chk: assert (!(shf_sel == 2'b11 && alu_sel == 3'b000) || result[WIDTH-1] == opa[WIDTH-1]);
        // R11
        sign_flag_chk: assert (flag_s == result[WIDTH-1]);
        // R10
        zero_flag_chk: assert (!flag_z || result == '0);
    end

endmodule

bind alu_shift_unit alu_shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .opa     (opa),
    .opb     (opb),
    .alu_sel (alu_sel),
    .shf_sel (shf_sel),
    .result  (result),
    .flag_z  (flag_z),
    .flag_s  (flag_s),
    .flag_c  (flag_c),
    .flag_v  (flag_v)
);

// File: tb/alu_shift_unit_bench.sv
module alu_shift_unit_bench;

    logic        clk = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [2:0]  alu_sel = '0;
    logic [1:0]  shf_sel = '0;
    logic [15:0] result;
    logic        flag_z, flag_s, flag_c, flag_v;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    alu_shift_unit u_alu_shift_unit (
        .opa     (opa),
        .opb     (opb),
        .alu_sel (alu_sel),
        .shf_sel (shf_sel),
        .result  (result),
        .flag_z  (flag_z),
        .flag_s  (flag_s),
        .flag_c  (flag_c),
        .flag_v  (flag_v)
    );

    function automatic logic [15:0] pick(input int idx);
        logic [15:0] x;
        case (idx)
            0: x = 16'h0000;  1: x = 16'h0001;  2: x = 16'h0002;  3: x = 16'h7FFF;
            4: x = 16'h8000;  5: x = 16'h8001;  6: x = 16'hFFFF;  7: x = 16'hFFFE;
            8: x = 16'h5555;  9: x = 16'hAAAA; 10: x = 16'h00FF; 11: x = 16'hFF00;
           12: x = 16'h0F0F; 13: x = 16'h4000; 14: x = 16'hC000; 15: x = 16'h1234;
            default: x = 16'((idx * 40503 + 12345) ^ (idx << 9));
        endcase
        return x;
    endfunction

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h (a=%h b=%h op=%b sh=%b)",
                     req, what, act, exp, opa, opb, alu_sel, shf_sel);
        end
    endtask

    task automatic run_vec(input logic [15:0] a, input logic [15:0] b,
                           input logic [2:0] op, input logic [1:0] sh);
        int sa, sb, wide, st1, fin, ec, ev;
        string rres;
        @(negedge clk);
        opa = a; opb = b; alu_sel = op; shf_sel = sh;
        #1;
        sa = int'($signed(a)); sb = int'($signed(b));
        ec = 0; ev = 0;
        case (op)
            3'b000: begin st1 = int'(a); rres = "R1"; end
            3'b001: begin st1 = int'(b); rres = "R1"; end
            3'b010: begin
                wide = int'(a) + int'(b); st1 = wide % 65536; ec = (wide > 65535) ? 1 : 0;
                ev = ((sa + sb) > 32767 || (sa + sb) < -32768) ? 1 : 0; rres = "R2";
            end
            3'b011: begin
                wide = int'(a) - int'(b); st1 = (wide + 65536) % 65536; ec = (wide < 0) ? 1 : 0;
                ev = ((sa - sb) > 32767 || (sa - sb) < -32768) ? 1 : 0; rres = "R3";
            end
            3'b100: begin st1 = 65535 - int'(a); rres = "R4"; end
            3'b101: begin st1 = 65535 - int'(b); rres = "R4"; end
            3'b110: begin st1 = int'(a & b); rres = "R5"; end
            default: begin st1 = int'(a | b); rres = "R5"; end
        endcase
        case (sh)
            2'b00: fin = st1;
            2'b01: begin fin = (st1 * 2) % 65536; rres = "R7"; end
            2'b10: begin fin = st1 / 2; rres = "R8"; end
            default: begin fin = st1 / 2 + ((st1 >= 32768) ? 32768 : 0); rres = "R9"; end
        endcase
        expect_eq(rres, "result", int'(result), fin);
        expect_eq("R10", "zero", int'(flag_z), (fin == 0) ? 1 : 0);
        expect_eq("R11", "sign", int'(flag_s), (fin >= 32768) ? 1 : 0);
        if (op == 3'b010) begin
            expect_eq("R2", "carry", int'(flag_c), ec);
            expect_eq("R2", "ovf", int'(flag_v), ev);
        end else if (op == 3'b011) begin
            expect_eq("R3", "carry", int'(flag_c), ec);
            expect_eq("R3", "ovf", int'(flag_v), ev);
        end else begin
            expect_eq("R6", "carry", int'(flag_c), 0);
            expect_eq("R6", "ovf", int'(flag_v), 0);
        end
    endtask

    initial begin
        // quiescent state: all-zero inputs give zero result, Z set (R10, R1)
        @(negedge clk); #1;
        expect_eq("R1", "idle result", int'(result), 0);
        expect_eq("R10", "idle zero", int'(flag_z), 1);
        // shifted-out carry bit must not reach C: 0x8000+0x8000 shifted left (R7)
        run_vec(16'h8000, 16'h8000, 3'b010, 2'b01);
        // nonzero sum emptied by right shift (R10)
        run_vec(16'h0000, 16'h0001, 3'b010, 2'b10);
        for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++)
                for (int k = 0; k < 32; k++)
                    run_vec(pick(i), pick(j), 3'(k >> 2), 2'(k & 3));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule